// File: doc/BRIEF.md
# Reference Clock Loss-of-Lock Monitor

This block supervises a clock multiplier and reports its lock state on a single status pin. It observes two clocks: the reference that feeds the multiplier, and a feedback clock taken from the multiplied output after division back to the reference rate. Both are sampled by a free-running monitor clock, which must run at more than twice the faster of the two.

The status pin has three behaviours. It stays high while the feedback rate matches the reference. It stays low while the reference has stopped, whether it is stuck high, stuck low or floating. It toggles as a slow pulse train while the reference runs but the feedback rate disagrees with it. Presence is judged by a watchdog that is cleared by every reference rising edge. Rate agreement is judged over a window of a fixed number of reference rising edges, during which feedback rising edges are counted and compared against the window length within a tolerance.

Lock needs two good windows in a row and is dropped after one bad window. While unlocked, the pin changes at most once per window, so its rate is the reference rate divided by twice the window length or less.

Top module: `refLockMonitor`

## Requirements
- R1: While the monitor is in the locked state, `lockStatus` is 1 on every monitor clock cycle.
- R2: When the reference stops toggling, held at either 1 or 0, `lockStatus` is 0 from at most WATCHDOG_CYCLES + 16 monitor cycles after its last rising edge, and stays 0 while it remains stopped.
- R3: The reference counts as absent once WATCHDOG_CYCLES monitor cycles pass with no reference rising edge. One rising edge makes it present again and starts a fresh window, and the monitor locks again once the ratio is correct.
- R4: A window spans WINDOW_EDGES reference rising edges. It is in tolerance when the number of feedback rising edges counted in it differs from WINDOW_EDGES by at most TOLERANCE.
- R5: While the reference is present but the monitor is not locked, `lockStatus` inverts once per out-of-tolerance window. It changes only in the cycle after a window ends or after absence is detected.
- R6: Lock is declared only after two consecutive in-tolerance windows. A single good window while hunting does not change `lockStatus`.
- R7: One out-of-tolerance window while locked leaves the locked state, and `lockStatus` falls to 0 in the next cycle.
- R8: After reset, the reference is treated as absent and `lockStatus` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running monitor clock |
| rstN | input | 1 | Active-low synchronous reset |
| refClk | input | 1 | Reference clock under watch (asynchronous) |
| fbClk | input | 1 | Divided feedback clock from the multiplier (asynchronous) |
| lockStatus | output | 1 | High when locked, low when the reference is absent, toggling when unlocked |

## Verification
The bench builds the block with a window of 16 reference edges, a tolerance of 1 and a 64-cycle watchdog. With an 80 ns reference and a 4 ns monitor clock, one window lasts about 320 monitor cycles, so acquisition, loss, relock and several pulse-train periods all fit in a short run. Feedback periods of 78 ns and 70 ns give about 16.4 and 18.3 counts per window, which fall inside and outside the tolerance band. The stopped reference is held both high and low, and the run outlasts the watchdog each time.

// File: rtl/refMonPkg.sv
`timescale 1ns/1ps
package refMonPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;     // clear window counters, start a fresh window
  } ctrlStrobes_t;

  // Observations from datapath to control
  typedef struct packed {
    logic refAbsent;   // watchdog expired
    logic windowDone;  // last reference edge of a window seen this cycle
    logic inTol;       // feedback count of the ending window is in tolerance
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_ABSENT = 2'd0,
    ST_HUNT   = 2'd1,
    ST_LOCKED = 2'd2
  } monState_t;

endpackage

// File: rtl/refMonSync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer with rising-edge detection
module refMonSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              lastLevel;

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= 1'b0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) chain[s] <= 1'b0;
      else       chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~lastLevel;
endmodule

// File: rtl/refMonDatapath.sv
`timescale 1ns/1ps
module refMonDatapath
  import refMonPkg::*;
#(
  parameter int WINDOW_EDGES    = 16,
  parameter int TOLERANCE       = 1,
  parameter int WATCHDOG_CYCLES = 64,
  parameter int SYNC_STAGES     = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         refClk,
  input  logic         fbClk,
  input  ctrlStrobes_t strobes,
  output dpStatus_t    status
);
  localparam int WD_W  = $clog2(WATCHDOG_CYCLES + 1);
  localparam int WIN_W = $clog2(WINDOW_EDGES);
  localparam int FB_W  = $clog2(WINDOW_EDGES + TOLERANCE + 2) + 1;

  localparam logic [WD_W-1:0]  WD_LIMIT = WD_W'(WATCHDOG_CYCLES);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_EDGES - 1);
  localparam logic [FB_W-1:0]  FB_MAX   = '1;
  localparam logic [FB_W-1:0]  FB_LOW   = (WINDOW_EDGES > TOLERANCE) ?
                                          FB_W'(WINDOW_EDGES - TOLERANCE) : '0;
  localparam logic [FB_W-1:0]  FB_HIGH  = FB_W'(WINDOW_EDGES + TOLERANCE);

  logic             refRise, fbRise;
  logic [WD_W-1:0]  wdCount;
  logic [WIN_W-1:0] refCount;
  logic [FB_W-1:0]  fbCount, fbNext;
  logic             windowEnd;

  refMonSync #(.STAGES(SYNC_STAGES)) uRefSync (
    .clk(clk), .rstN(rstN), .asyncIn(refClk), .rise(refRise)
  );

  refMonSync #(.STAGES(SYNC_STAGES)) uFbSync (
    .clk(clk), .rstN(rstN), .asyncIn(fbClk), .rise(fbRise)
  );

  // Watchdog: cleared by each reference edge, saturates at its limit
  always_ff @(posedge clk) begin
    if (!rstN)                  wdCount <= WD_LIMIT;
    else if (refRise)           wdCount <= '0;
    else if (wdCount != WD_LIMIT) wdCount <= wdCount + 1'b1;
  end

  // Feedback count including an edge arriving this cycle, saturating
  always_comb begin
    fbNext = fbCount;
    if (fbRise && (fbCount != FB_MAX)) fbNext = fbCount + 1'b1;
  end

  assign windowEnd = refRise && !strobes.restart && (refCount == WIN_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.restart) begin
      refCount <= '0;
      fbCount  <= '0;
    end else if (windowEnd) begin
      refCount <= '0;
      fbCount  <= '0;
    end else begin
      if (refRise) refCount <= refCount + 1'b1;
      fbCount <= fbNext;
    end
  end

  always_comb begin
    status.refAbsent  = (wdCount == WD_LIMIT);
    status.windowDone = windowEnd;
    status.inTol      = (fbNext >= FB_LOW) && (fbNext <= FB_HIGH);
  end
endmodule

// File: rtl/refMonControl.sv
`timescale 1ns/1ps
module refMonControl
  import refMonPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         lockedFlag,
  output logic         lockStatus
);
  monState_t state;
  logic      goodPending;
  logic      toggleBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_ABSENT;
      goodPending <= 1'b0;
      toggleBit   <= 1'b0;
    end else if (status.refAbsent) begin
      state       <= ST_ABSENT;
      goodPending <= 1'b0;
      toggleBit   <= 1'b0;
    end else begin
      unique case (state)
        ST_ABSENT: state <= ST_HUNT;
        ST_HUNT: begin
          if (status.windowDone) begin
            if (status.inTol) begin
              if (goodPending) begin
                state     <= ST_LOCKED;
                toggleBit <= 1'b1;
              end
              goodPending <= 1'b1;
            end else begin
              goodPending <= 1'b0;
              toggleBit   <= ~toggleBit;
            end
          end
        end
        ST_LOCKED: begin
          if (status.windowDone && !status.inTol) begin
            state       <= ST_HUNT;
            goodPending <= 1'b0;
            toggleBit   <= 1'b0;
          end
        end
        default: state <= ST_ABSENT;
      endcase
    end
  end

  always_comb begin
    strobes.restart = (state == ST_ABSENT);
    lockedFlag      = (state == ST_LOCKED);
    lockStatus      = lockedFlag || ((state == ST_HUNT) && toggleBit);
  end
endmodule

// File: rtl/refLockMonitor.sv
`timescale 1ns/1ps
module refLockMonitor
  import refMonPkg::*;
#(
  parameter int WINDOW_EDGES    = 16,
  parameter int TOLERANCE       = 1,
  parameter int WATCHDOG_CYCLES = 64,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refClk,
  input  logic fbClk,
  output logic lockStatus
);
  ctrlStrobes_t ctrlStrobes;
  dpStatus_t    dpStatus;
  logic         lockedFlag;

  refMonDatapath #(
    .WINDOW_EDGES(WINDOW_EDGES),
    .TOLERANCE(TOLERANCE),
    .WATCHDOG_CYCLES(WATCHDOG_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .refClk(refClk), .fbClk(fbClk),
    .strobes(ctrlStrobes), .status(dpStatus)
  );

  refMonControl uControl (
    .clk(clk), .rstN(rstN), .status(dpStatus), .strobes(ctrlStrobes),
    .lockedFlag(lockedFlag), .lockStatus(lockStatus)
  );
endmodule

// File: rtl/refLockMonitorChecker.sv
`timescale 1ns/1ps
module refLockMonitorChecker
  import refMonPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      lockStatus,
  input logic      lockedFlag,
  input dpStatus_t dpStatus
);
  // Consecutive in-tolerance windows, saturating at 2
  logic [1:0] goodStreak;

  always_ff @(posedge clk) begin
    if (!rstN || dpStatus.refAbsent) goodStreak <= 2'd0;
    else if (dpStatus.windowDone) begin
      if (!dpStatus.inTol)        goodStreak <= 2'd0;
      else if (goodStreak != 2'd2) goodStreak <= goodStreak + 2'd1;
    end
  end

  a_r1_locked_high: assert property (@(posedge clk) disable iff (!rstN)
    lockedFlag |-> lockStatus);

  a_r2_absent_low: assert property (@(posedge clk) disable iff (!rstN)
    dpStatus.refAbsent |=> !lockStatus);

  a_r5_change_at_events: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockStatus) |-> ($past(dpStatus.windowDone) || $past(dpStatus.refAbsent)));

  a_r6_two_good_windows: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedFlag) |-> (goodStreak == 2'd2));

  a_r7_one_bad_window: assert property (@(posedge clk) disable iff (!rstN)
    (dpStatus.windowDone && !dpStatus.inTol) |=> !lockedFlag);
endmodule

bind refLockMonitor refLockMonitorChecker uChk (
  .clk(clk), .rstN(rstN), .lockStatus(lockStatus),
  .lockedFlag(lockedFlag), .dpStatus(dpStatus)
);

// File: tb/refLockMonitor_test.sv
`timescale 1ns/1ps
module refLockMonitor_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refClk = 1'b0;
  logic fbClk = 1'b0;
  logic lockStatus;

  logic refRun = 1'b0;
  logic refStuck = 1'b0;
  int   refHalf = 40;
  int   fbHalf = 40;

  int checks = 0;
  int errors = 0;
  int obsOnes, obsZeros, obsEdges, obsMinGap;

  refLockMonitor #(
    .WINDOW_EDGES(16), .TOLERANCE(1), .WATCHDOG_CYCLES(64), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rstN(rstN), .refClk(refClk), .fbClk(fbClk), .lockStatus(lockStatus)
  );

  initial forever #2 clk = ~clk;

  always begin
    if (refRun) begin
      #(refHalf) refClk = ~refClk;
    end else begin
      refClk = refStuck;
      #4;
    end
  end

  always begin
    #(fbHalf) fbClk = ~fbClk;
  end

  task automatic check(input logic ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic observe(input int cycles);
    logic prev;
    int gap;
    obsOnes = 0; obsZeros = 0; obsEdges = 0; obsMinGap = 1000000; gap = 0;
    @(negedge clk);
    prev = lockStatus;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      gap++;
      if (lockStatus) obsOnes++; else obsZeros++;
      if (lockStatus !== prev) begin
        obsEdges++;
        if (obsEdges > 1 && gap < obsMinGap) obsMinGap = gap;
        gap = 0;
      end
      prev = lockStatus;
    end
  endtask

  task automatic testReset();
    refRun = 1'b0; refStuck = 1'b0; rstN = 1'b0;
    waitCycles(10);
    check(lockStatus == 1'b0, "R8 status in reset", lockStatus, 0);
    rstN = 1'b1;
    observe(200);
    check(obsOnes == 0, "R8 low after reset", obsOnes, 0);
  endtask

  task automatic testAcquire();
    fbHalf = 40;
    refRun = 1'b1;
    observe(560);
    check(obsOnes == 0, "R6 no lock after one good window", obsOnes, 0);
    waitCycles(400);
    observe(960);
    check(obsZeros == 0, "R1 steady high when locked", obsZeros, 0);
    check(obsEdges == 0, "R1 no transitions when locked", obsEdges, 0);
  endtask

  task automatic testLossAndPulse();
    fbHalf = 35;
    observe(700);
    check(obsZeros > 0, "R7 drop after bad window", obsZeros, 1);
    observe(1920);
    check(obsEdges >= 4 && obsEdges <= 8, "R5 one toggle per window", obsEdges, 6);
    check(obsMinGap >= 250, "R5 toggle spacing", obsMinGap, 320);
    check(obsOnes > 0 && obsZeros > 0, "R4 ratio outside tolerance toggles", obsEdges, 6);
  endtask

  task automatic testTolerance();
    fbHalf = 39;
    waitCycles(1300);
    observe(960);
    check(obsZeros == 0, "R4 ratio inside tolerance locks", obsZeros, 0);
  endtask

  task automatic testStuck(input logic level);
    refStuck = level;
    refRun = 1'b0;
    waitCycles(100);
    observe(600);
    check(obsOnes == 0, level ? "R2 stuck high low" : "R2 stuck low low", obsOnes, 0);
    refRun = 1'b1;
    waitCycles(1300);
    observe(400);
    check(obsZeros == 0, "R3 relock after reference returns", obsZeros, 0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testAcquire();
        testLossAndPulse();
        testTolerance();
        testStuck(1'b1);
        fbHalf = 40;
        testStuck(1'b0);
      end
      begin
        waitCycles(200000);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule